// File: doc/BRIEF.md
# Burst DRAM Bank-ID Initialization Sequencer

This block brings up a bus of cascaded burst DRAM devices after power-on. When it is started it first sends the memory reset sequence to every device at once. It then walks through every bank-ID register of every device except device 0 and rewrites each one with its target value. Once this is done, all devices answer in one flat address space, and no external address decoding is needed. Each device holds 32 banks. Pairs of banks share one 7-bit ID that is carried on address bits 15 to 9, so each device has 16 ID registers.

One command is issued per clock cycle. Command and address values are presented from registered state. Each device has its own active-low chip select, so only the device being reprogrammed sees the ID-write traffic. The command opcodes and the old and new ID tables are parameters. The tables are packed 7 bits per entry, with entry (d, r) at bit offset (d*16 + r)*7.

Top module: `mdinit_sequencer`

## Requirements
- R1: A start seen while idle or done issues the reset opcode (default 4'hF) in the next cycle, followed by exactly two STOP opcodes (default 4'h0). In all three cycles every chip select is low and the address is zero.
- R2: Each ID register is rewritten by three consecutive commands: ID-write (default 4'h6), STOP, STOP.
- R3: During the ID-write cycle, address bits 15 to 9 carry the register's old ID and bits 8 to 0 are zero.
- R4: During the first STOP after an ID-write, address bits 15 to 9 carry the register's new ID.
- R5: During the second STOP, the new ID and the chip-select pattern are held unchanged from the first STOP.
- R6: During every ID-write, STOP, STOP triple, exactly one chip select is low: the one of the device being reprogrammed.
- R7: Device 0 is never reprogrammed. Devices 1 to NUM_DEV-1 are visited in ascending order, and within a device registers 0 to 15 are visited in ascending order.
- R8: Done goes high in the cycle after the last STOP of the final device, or directly after the reset triple when NUM_DEV is 1. While done is high, all chip selects are low and the command is STOP. Done stays high until the next start.
- R9: Out of reset, and until the first start, the command is STOP, the address is zero, all chip selects are high and done is low. An asynchronous reset during a run returns the block to this state.
- R10: A start received while a sequence is running has no effect on the command stream.
- R11: A start received while done is high clears done and runs the whole sequence again.
- R12: With the default tables, the old ID of register r is r on every device, and the new ID of register r on device d is d*16 + r.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run the initialization sequence |
| done_o | output | 1 | High once all ID registers are rewritten |
| cmd_o | output | 4 | Command opcode to the devices |
| adq_o | output | 16 | Address/data bus value; ID field in bits 15:9 |
| cs_n_o | output | NUM_DEV | Active-low chip select, one per device |

## Verification
The bench runs three devices and checks every cycle of the command stream. A design that skipped a STOP or reset the register counter wrongly would shift every later vector. A design that released the new ID before the second STOP would show the old value or zero in that cycle. The bench pulses start in the middle of the reprogramming walk; a sequencer that restarted on it would put the reset opcode back on the bus. Further checks cover the switch from device 1 to device 2, where a wrong chip-select decode would select two devices or the wrong one, and the single cycle in which done must appear. Restart from done and a reset in the middle of a run are also covered.

// File: rtl/mdinit_pkg.sv
package mdinit_pkg;

    localparam int MAX_DEV = 8;
    localparam int MAX_REG = 16;
    localparam int ID_W    = 7;
    localparam int TABLE_W = MAX_DEV * MAX_REG * ID_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RST,
        PH_RST_S1,
        PH_RST_S2,
        PH_WR,
        PH_WR_S1,
        PH_WR_S2,
        PH_DONE
    } phase_e;

    typedef logic [2:0]      dev_idx_t;
    typedef logic [3:0]      reg_idx_t;
    typedef logic [ID_W-1:0] bank_id_t;

    // Power-up value of ID register r: r on every device.
    function automatic logic [TABLE_W-1:0] default_old_ids();
        logic [TABLE_W-1:0] tbl;
        tbl = '0;
        for (int d = 0; d < MAX_DEV; d++) begin
            for (int r = 0; r < MAX_REG; r++) begin
                tbl[(d*MAX_REG + r)*ID_W +: ID_W] = ID_W'(r);
            end
        end
        return tbl;
    endfunction

    // Target value: device d, register r gets d*16 + r.
    function automatic logic [TABLE_W-1:0] default_new_ids();
        logic [TABLE_W-1:0] tbl;
        tbl = '0;
        for (int d = 0; d < MAX_DEV; d++) begin
            for (int r = 0; r < MAX_REG; r++) begin
                tbl[(d*MAX_REG + r)*ID_W +: ID_W] = ID_W'(d*MAX_REG + r);
            end
        end
        return tbl;
    endfunction

endpackage

// File: rtl/mdinit_ctrl.sv
module mdinit_ctrl
    import mdinit_pkg::*;
#(
    parameter int NUM_DEV = 2,
    parameter int NUM_REG = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    output phase_e   phase_o,
    output dev_idx_t dev_o,
    output reg_idx_t reg_o
);

    localparam dev_idx_t LAST_DEV = dev_idx_t'(NUM_DEV - 1);
    localparam reg_idx_t LAST_REG = reg_idx_t'(NUM_REG - 1);
    localparam bit       HAS_PEERS = (NUM_DEV > 1);

    typedef struct packed {
        phase_e   phase;
        dev_idx_t dev;
        reg_idx_t rsel;
    } ctrl_t;

    ctrl_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE, PH_DONE: begin
                if (start_i) begin
                    st_d.phase = PH_RST;
                    st_d.dev   = '0;
                    st_d.rsel  = '0;
                end
            end
            PH_RST:    st_d.phase = PH_RST_S1;
            PH_RST_S1: st_d.phase = PH_RST_S2;
            PH_RST_S2: begin
                if (HAS_PEERS) begin
                    st_d.phase = PH_WR;
                    st_d.dev   = dev_idx_t'(1);
                    st_d.rsel  = '0;
                end else begin
                    st_d.phase = PH_DONE;
                end
            end
            PH_WR:     st_d.phase = PH_WR_S1;
            PH_WR_S1:  st_d.phase = PH_WR_S2;
            PH_WR_S2: begin
                if (st_q.rsel != LAST_REG) begin
                    st_d.phase = PH_WR;
                    st_d.rsel  = st_q.rsel + reg_idx_t'(1);
                end else if (st_q.dev != LAST_DEV) begin
                    st_d.phase = PH_WR;
                    st_d.dev   = st_q.dev + dev_idx_t'(1);
                    st_d.rsel  = '0;
                end else begin
                    st_d.phase = PH_DONE;
                end
            end
            default:   st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, dev: '0, rsel: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign dev_o   = st_q.dev;
    assign reg_o   = st_q.rsel;

    AST_DEV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase inside {PH_WR, PH_WR_S1, PH_WR_S2}) |->
            (st_q.dev != '0 && st_q.dev <= LAST_DEV && st_q.rsel <= LAST_REG)) // R7
        else $error("device or register index out of range");

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !(st_q.phase inside {PH_IDLE, PH_DONE})) |=> (st_q.phase != PH_RST)) // R10
        else $error("start restarted a running sequence");

endmodule

// File: rtl/mdinit_id_sel.sv
module mdinit_id_sel
    import mdinit_pkg::*;
#(
    parameter logic [TABLE_W-1:0] OLD_IDS = default_old_ids(),
    parameter logic [TABLE_W-1:0] NEW_IDS = default_new_ids()
) (
    input  dev_idx_t dev_i,
    input  reg_idx_t reg_i,
    output bank_id_t old_id_o,
    output bank_id_t new_id_o
);

    logic [9:0] base;

    always_comb begin
        base     = 10'((int'(dev_i) * MAX_REG + int'(reg_i)) * ID_W);
        old_id_o = OLD_IDS[base +: ID_W];
        new_id_o = NEW_IDS[base +: ID_W];
    end

endmodule

// File: rtl/mdinit_bus_drv.sv
module mdinit_bus_drv
    import mdinit_pkg::*;
#(
    parameter int         NUM_DEV  = 2,
    parameter logic [3:0] OP_RESET = 4'hF,
    parameter logic [3:0] OP_STOP  = 4'h0,
    parameter logic [3:0] OP_IDWR  = 4'h6
) (
    input  phase_e             phase_i,
    input  dev_idx_t           dev_i,
    input  bank_id_t           old_id_i,
    input  bank_id_t           new_id_i,
    output logic [3:0]         cmd_o,
    output logic [15:0]        adq_o,
    output logic [NUM_DEV-1:0] cs_n_o,
    output logic               done_o
);

    logic sel_all;
    logic sel_one;

    always_comb begin
        cmd_o   = OP_STOP;
        adq_o   = '0;
        sel_all = 1'b0;
        sel_one = 1'b0;
        done_o  = 1'b0;
        unique case (phase_i)
            PH_RST: begin
                cmd_o   = OP_RESET;
                sel_all = 1'b1;
            end
            PH_RST_S1, PH_RST_S2: sel_all = 1'b1;
            PH_WR: begin
                cmd_o   = OP_IDWR;
                adq_o   = {old_id_i, 9'b0};
                sel_one = 1'b1;
            end
            PH_WR_S1, PH_WR_S2: begin
                adq_o   = {new_id_i, 9'b0};
                sel_one = 1'b1;
            end
            PH_DONE: begin
                sel_all = 1'b1;
                done_o  = 1'b1;
            end
            default: ;
        endcase
    end

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_cs
        assign cs_n_o[g] = !(sel_all || (sel_one && dev_i == dev_idx_t'(g)));
    end

endmodule

// File: rtl/mdinit_sequencer.sv
module mdinit_sequencer
    import mdinit_pkg::*;
#(
    parameter int                 NUM_DEV  = 2,
    parameter int                 NUM_REG  = 16,
    parameter logic [3:0]         OP_RESET = 4'hF,
    parameter logic [3:0]         OP_STOP  = 4'h0,
    parameter logic [3:0]         OP_IDWR  = 4'h6,
    parameter logic [TABLE_W-1:0] OLD_IDS  = default_old_ids(),
    parameter logic [TABLE_W-1:0] NEW_IDS  = default_new_ids()
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    output logic               done_o,
    output logic [3:0]         cmd_o,
    output logic [15:0]        adq_o,
    output logic [NUM_DEV-1:0] cs_n_o
);

    phase_e   phase;
    dev_idx_t dev;
    reg_idx_t rsel;
    bank_id_t old_id;
    bank_id_t new_id;

    mdinit_ctrl #(
        .NUM_DEV (NUM_DEV),
        .NUM_REG (NUM_REG)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .phase_o (phase),
        .dev_o   (dev),
        .reg_o   (rsel)
    );

    mdinit_id_sel #(
        .OLD_IDS (OLD_IDS),
        .NEW_IDS (NEW_IDS)
    ) u_id_sel (
        .dev_i    (dev),
        .reg_i    (rsel),
        .old_id_o (old_id),
        .new_id_o (new_id)
    );

    mdinit_bus_drv #(
        .NUM_DEV  (NUM_DEV),
        .OP_RESET (OP_RESET),
        .OP_STOP  (OP_STOP),
        .OP_IDWR  (OP_IDWR)
    ) u_bus_drv (
        .phase_i  (phase),
        .dev_i    (dev),
        .old_id_i (old_id),
        .new_id_i (new_id),
        .cmd_o    (cmd_o),
        .adq_o    (adq_o),
        .cs_n_o   (cs_n_o),
        .done_o   (done_o)
    );

    AST_RESET_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == OP_RESET) |=> (cmd_o == OP_STOP && cs_n_o == '0)
                                ##1 (cmd_o == OP_STOP && cs_n_o == '0)) // R1
        else $error("reset opcode not followed by two STOPs");

    AST_IDWR_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == OP_IDWR) |=> (cmd_o == OP_STOP) ##1 (cmd_o == OP_STOP)) // R2
        else $error("ID-write not followed by two STOPs");

    AST_NEW_ID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_o == OP_IDWR, 2) |-> ($stable(adq_o) && $stable(cs_n_o))) // R5
        else $error("new ID or chip select changed before second STOP");

    AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == OP_IDWR) |-> ($countones(~cs_n_o) == 1 && cs_n_o[0])) // R6
        else $error("chip select pattern wrong during ID-write");

    AST_DONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o == '0 && cmd_o == OP_STOP)) // R8
        else $error("done with wrong bus state");

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o) // R8
        else $error("done dropped without start");

endmodule

// File: tb/mdinit_sequencer_tb.sv
`timescale 1ns/1ps
module mdinit_sequencer_tb;

    localparam int NDEV   = 3;
    localparam int NREG   = 16;
    localparam int LAST_C = 3 + 3*NREG*(NDEV-1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic            done_o;
    logic [3:0]      cmd_o;
    logic [15:0]     adq_o;
    logic [NDEV-1:0] cs_n_o;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    // {cmd, adq, cs_n, done} for the first cycles after start
    localparam logic [23:0] HEAD_TBL [9] = '{
        {4'hF, 16'h0000, 3'b000, 1'b0},
        {4'h0, 16'h0000, 3'b000, 1'b0},
        {4'h0, 16'h0000, 3'b000, 1'b0},
        {4'h6, 16'h0000, 3'b101, 1'b0},
        {4'h0, 16'h2000, 3'b101, 1'b0},
        {4'h0, 16'h2000, 3'b101, 1'b0},
        {4'h6, 16'h0200, 3'b101, 1'b0},
        {4'h0, 16'h2200, 3'b101, 1'b0},
        {4'h0, 16'h2200, 3'b101, 1'b0}
    };
    localparam logic [23:0] IDLE_VEC = {4'h0, 16'h0000, 3'b111, 1'b0};

    always #2.5 clk = ~clk;

    mdinit_sequencer #(.NUM_DEV(NDEV)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .done_o  (done_o),
        .cmd_o   (cmd_o),
        .adq_o   (adq_o),
        .cs_n_o  (cs_n_o)
    );

    function automatic logic [23:0] obs();
        return {cmd_o, adq_o, cs_n_o, done_o};
    endfunction

    function automatic logic [23:0] exp_at(int c);
        int k, ph, dv, r;
        logic [6:0] idv;
        logic [2:0] csn;
        if (c < 3) return {(c == 0) ? 4'hF : 4'h0, 16'h0000, 3'b000, 1'b0};
        if (c >= LAST_C) return {4'h0, 16'h0000, 3'b000, 1'b1};
        k   = (c - 3) / 3;
        ph  = (c - 3) % 3;
        dv  = 1 + k / NREG;
        r   = k % NREG;
        idv = (ph == 0) ? 7'(r) : 7'(dv*16 + r);
        csn = ~(3'(1 << dv));
        return {(ph == 0) ? 4'h6 : 4'h0, {idv, 9'b0}, csn, 1'b0};
    endfunction

    function automatic string tag_at(int c);
        if (c < 3) return "R1";
        if (c >= LAST_C) return "R8";
        case ((c - 3) % 3)
            0:       return "R2 R3 R6 R7 R12";
            1:       return "R2 R4 R6 R12";
            default: return "R2 R5 R6";
        endcase
    endfunction

    task automatic chk(bit ok, string tag, logic [23:0] act, logic [23:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Walk cycles c_from..LAST_C; pulse start just before cycle pulse_at+1.
    task automatic walk(int c_from, int pulse_at);
        for (int c = c_from; c <= LAST_C; c++) begin
            chk(obs() == exp_at(c), (c == pulse_at + 1) ? "R10" : tag_at(c), obs(), exp_at(c));
            start_i = (c == pulse_at);
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(obs() == IDLE_VEC, "R9 in reset", obs(), IDLE_VEC);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(obs() == IDLE_VEC, "R9 idle", obs(), IDLE_VEC);
        end

        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 9; i++) begin
            chk(obs() == HEAD_TBL[i], tag_at(i), obs(), HEAD_TBL[i]);
            @(negedge clk);
        end
        walk(9, 40);

        for (int i = 0; i < 5; i++) begin
            chk(obs() == exp_at(LAST_C), "R8 hold", obs(), exp_at(LAST_C));
            @(negedge clk);
        end

        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(obs() == exp_at(0), "R11 restart", obs(), exp_at(0));
        @(negedge clk);
        walk(1, -5);

        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(obs() == IDLE_VEC, "R9 mid-run reset", obs(), IDLE_VEC);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(obs() == IDLE_VEC, "R9 after reset", obs(), IDLE_VEC);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule